// File: doc/BRIEF.md
# Synthesizer Programming Receiver (I2C slave)

This block is a write-mostly I2C slave. It loads the control word of a frequency synthesizer. SCL and SDA arrive already synchronised to the system clock. The block detects START, STOP and SCL edges by comparing each input with its value one clock earlier. The device address is the fixed prefix `11000` followed by two strap pins and the R/W bit. After the address, a write carries two or four data bytes taken as byte pairs. Bit 7 of the first byte of each pair selects where the pair goes: 0 selects the 15-bit divide ratio, 1 selects the control/band pair. A read returns one status byte, then the block waits for the next START or STOP.

A register group changes only when both bytes of its pair have been acknowledged. A one-cycle strobe then names that group. SDA is open drain: `sda_oe` high means the block pulls the line low.

The state machine has eight states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WR_BYTE`: shifts in a data byte.
- `ST_WR_ACK`: drives a data acknowledge and commits pairs.
- `ST_RD_BYTE`: shifts out the status byte.
- `ST_RD_ACK`: the master's acknowledge slot.
- `ST_SKIP`: ignores the bus until START or STOP.

The transitions are:
- A STOP from any state goes to `ST_IDLE`. A START from any state goes to `ST_ADDR`.
- `ST_ADDR` goes on the SCL fall after bit 8: to `ST_ADDR_ACK` on an address match, otherwise to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` (R/W=1) or `ST_WR_BYTE` (R/W=0).
- `ST_WR_BYTE` goes to `ST_WR_ACK` while fewer than four bytes have been taken, otherwise to `ST_SKIP`.
- `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK`, then to `ST_SKIP`.

Top module: `synth_ctl_rx`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth SCL high phase) an address byte equal to `1,1,0,0,0,addr_sel[1],addr_sel[0],R/W`, and every accepted data byte. Any other address receives no acknowledge, and the transaction changes no register.
- R2: A pair whose first byte has bit 7 = 0 sets `div_ratio` = {first[6:0], second[7:0]}.
- R3: A pair whose first byte has bit 7 = 1 sets `ctl_bits` = first[5:0] (T2,T1,T0,Rsa,Rsb,OS from bit 5 down) and `band_sel` = second[3:0]. Bit 6 of the first byte and bits 7:4 of the second byte are discarded.
- R4: A four-byte write updates both groups, in either order (control/band then divider, or divider then control/band).
- R5: A lone first byte of a pair, followed by STOP, changes nothing. Pairs completed earlier in the same write are kept.
- R6: A fifth and any further data byte of a write is not acknowledged and has no effect.
- R7: A read returns one byte, MSB first, after the address acknowledge: {POR, `pll_locked`, 0, 0, 0, `aux_status[2:0]`}.
- R8: POR is 1 after reset and reads 0 once a status byte has been shifted out completely.
- R9: `upd_div` or `upd_ctl` pulses for exactly one clock per completed pair, in the same cycle the matching outputs change. The two strobes are never high together.
- R10: A repeated START discards any lone first byte and restarts the address phase.
- R11: After reset, `div_ratio`, `ctl_bits` and `band_sel` are 0, and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA |
| addr_sel | input | 2 | Strap bits completing the device address |
| pll_locked | input | 1 | Lock flag reported in the status byte |
| aux_status | input | 3 | Auxiliary status bits reported in the status byte |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or read data 0) |
| div_ratio | output | 15 | Divide ratio N14..N0 |
| ctl_bits | output | 6 | T2,T1,T0,Rsa,Rsb,OS |
| band_sel | output | 4 | Band switch BS4..BS1 |
| upd_div | output | 1 | One-cycle strobe: divider updated |
| upd_ctl | output | 1 | One-cycle strobe: control/band updated |

## Verification
The bench builds the block with the default parameters: prefix `11000`, at most four data bytes, a 15-bit divider, a 6-bit control field and a 4-bit band field. The strap pins are tied to `2'b10`. The bench sends addresses with the straps flipped, which exercises the rejection path. With four bytes as the limit, a fifth byte reaches the no-acknowledge path in a short frame. The fixed field widths let byte values with their don't-care bits set show that those bits are dropped.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } rx_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise = scl_i & ~scl_q;
        scl_fall = ~scl_i & scl_q;
        start_ev = scl_i & scl_q & sda_q & ~sda_i;
        stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/synth_rx_fsm.sv
module synth_rx_fsm
    import synth_ctl_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b11000,
    parameter int         MAX_DATA   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [1:0]         addr_sel,
    input  logic [BYTE_W-1:0]  status_in,
    output logic               sda_oe,
    output logic               pair_done,
    output logic [BYTE_W-1:0]  pair_b1,
    output logic [BYTE_W-1:0]  pair_b2,
    output logic               status_taken
);
    localparam int CNT_W = $clog2(MAX_DATA + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_DATA);

    rx_state_e          state, nxt;
    logic [3:0]         bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  rd_sh;
    logic [BYTE_W-1:0]  first_b;
    logic [CNT_W-1:0]   dcnt;
    logic               addr_hit;
    logic               room;
    logic               byte_end;

    assign addr_hit = (shreg[7:1] == {DEV_PREFIX, addr_sel});
    assign room     = (dcnt < CNT_MAX);
    assign byte_end = scl_fall && (bit_cnt == 4'd8);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) nxt = room ? ST_WR_ACK : ST_SKIP;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            rd_sh        <= '0;
            first_b      <= '0;
            dcnt         <= '0;
            sda_oe       <= 1'b0;
            pair_done    <= 1'b0;
            pair_b1      <= '0;
            pair_b2      <= '0;
            status_taken <= 1'b0;
        end else begin
            pair_done    <= 1'b0;
            status_taken <= 1'b0;
            if (start_ev || stop_ev) begin
                bit_cnt <= '0;
                dcnt    <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_i};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_end) begin
                            sda_oe  <= (state == ST_ADDR) ? addr_hit : room;
                            bit_cnt <= '0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (shreg[0]) begin
                                sda_oe <= ~status_in[7];
                                rd_sh  <= {status_in[6:0], 1'b0};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            dcnt   <= dcnt + 1'b1;
                            if (!dcnt[0]) begin
                                first_b <= shreg;
                            end else begin
                                pair_done <= 1'b1;
                                pair_b1   <= first_b;
                                pair_b2   <= shreg;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise && bit_cnt < 4'd8) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe       <= 1'b0;
                                status_taken <= 1'b1;
                            end else begin
                                sda_oe <= ~rd_sh[7];
                                rd_sh  <= {rd_sh[6:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R6
    data_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= CNT_MAX);

    // R9
    pair_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> !pair_done);

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR && bit_cnt == 4'd0));
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_ctl_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int CTL_W  = 6,
    parameter int BAND_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_done,
    input  logic [BYTE_W-1:0]  pair_b1,
    input  logic [BYTE_W-1:0]  pair_b2,
    input  logic               status_taken,
    output logic [DIV_W-1:0]   div_q,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [BAND_W-1:0]  band_q,
    output logic               upd_div,
    output logic               upd_ctl,
    output logic               por_q
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic is_ctl;
    assign is_ctl = pair_b1[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            ctl_q   <= '0;
            band_q  <= '0;
            upd_div <= 1'b0;
            upd_ctl <= 1'b0;
            por_q   <= 1'b1;
        end else begin
            upd_div <= pair_done & ~is_ctl;
            upd_ctl <= pair_done & is_ctl;
            if (pair_done && !is_ctl) div_q <= {pair_b1[HI_W-1:0], pair_b2};
            if (pair_done && is_ctl) begin
                ctl_q  <= pair_b1[CTL_W-1:0];
                band_q <= pair_b2[BAND_W-1:0];
            end
            if (status_taken) por_q <= 1'b0;
        end
    end

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> upd_div);

    // R3
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctl_q) || !$stable(band_q)) |-> upd_ctl);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_div, upd_ctl}));

    // R8
    por_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por_q));
endmodule

// File: rtl/synth_ctl_rx.sv
module synth_ctl_rx
    import synth_ctl_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b11000,
    parameter int         MAX_DATA   = 4,
    parameter int         DIV_W      = 15,
    parameter int         CTL_W      = 6,
    parameter int         BAND_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic              pll_locked,
    input  logic [2:0]        aux_status,
    output logic              sda_oe,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [CTL_W-1:0]  ctl_bits,
    output logic [BAND_W-1:0] band_sel,
    output logic              upd_div,
    output logic              upd_ctl
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic pair_done, status_taken, por_q;
    logic [BYTE_W-1:0] pair_b1, pair_b2, status_byte;

    assign status_byte = {por_q, pll_locked, 3'b000, aux_status};

    i2c_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    synth_rx_fsm #(
        .DEV_PREFIX (DEV_PREFIX),
        .MAX_DATA   (MAX_DATA)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .addr_sel     (addr_sel),
        .status_in    (status_byte),
        .sda_oe       (sda_oe),
        .pair_done    (pair_done),
        .pair_b1      (pair_b1),
        .pair_b2      (pair_b2),
        .status_taken (status_taken)
    );

    synth_reg_bank #(
        .DIV_W  (DIV_W),
        .CTL_W  (CTL_W),
        .BAND_W (BAND_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_done    (pair_done),
        .pair_b1      (pair_b1),
        .pair_b2      (pair_b2),
        .status_taken (status_taken),
        .div_q        (div_ratio),
        .ctl_q        (ctl_bits),
        .band_q       (band_sel),
        .upd_div      (upd_div),
        .upd_ctl      (upd_ctl),
        .por_q        (por_q)
    );
endmodule

// File: tb/synth_ctl_rx_tb.sv
`timescale 1ns/1ps
module synth_ctl_rx_tb;
    localparam time Q = 100ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic        pll_locked = 1'b0;
    logic [2:0]  aux_status = 3'b000;
    logic        sda_oe;
    logic [14:0] div_ratio;
    logic [5:0]  ctl_bits;
    logic [3:0]  band_sel;
    logic        upd_div, upd_ctl;
    logic        sda_line;

    int checks = 0;
    int fails = 0;
    int n_div = 0;
    int n_ctl = 0;
    bit done = 0;

    localparam logic [7:0] AW = 8'b1100_0100; // prefix 11000, straps 10, write
    localparam logic [7:0] AR = 8'b1100_0101; // read
    localparam logic [7:0] AX = 8'b1100_0010; // straps 01: mismatch

    assign sda_line = msda & ~sda_oe;

    always #10ns clk = ~clk;

    synth_ctl_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .addr_sel   (addr_sel),
        .pll_locked (pll_locked),
        .aux_status (aux_status),
        .sda_oe     (sda_oe),
        .div_ratio  (div_ratio),
        .ctl_bits   (ctl_bits),
        .band_sel   (band_sel),
        .upd_div    (upd_div),
        .upd_ctl    (upd_ctl)
    );

    always @(posedge clk) begin
        if (upd_div) n_div <= n_div + 1;
        if (upd_ctl) n_ctl <= n_ctl + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        msda = 1'b1; #Q; scl = 1'b1; #Q; msda = 1'b0; #Q; scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        msda = 1'b0; #Q; scl = 1'b1; #Q; msda = 1'b1; #Q; #(4*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
        end
        msda = 1'b1; #Q; scl = 1'b1; #Q;
        ack = ~sda_line;
        #Q; scl = 1'b0; #Q;
    endtask

    task automatic read_byte(output logic [7:0] b);
        msda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #Q; scl = 1'b1; #Q; b = {b[6:0], sda_line}; #Q; scl = 1'b0; #Q;
        end
        #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; // master NACK
    endtask

    task automatic t_reset();
        chk("R11 div reset", div_ratio, 0);
        chk("R11 ctl reset", ctl_bits, 0);
        chk("R11 band reset", band_sel, 0);
        chk("R11 sda released", sda_oe, 0);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start(); send_byte(AX, a);
        chk("R1 mismatched address not acked", a, 0);
        send_byte(8'h12, a); send_byte(8'h34, a);
        bus_stop();
        chk("R1 mismatched write ignored", div_ratio, 0);
        chk("R1 no strobe", n_div + n_ctl, 0);
    endtask

    task automatic t_div();
        logic a0, a1, a2;
        bus_start(); send_byte(AW, a0); send_byte(8'h12, a1); send_byte(8'h34, a2); bus_stop();
        chk("R1 address ack", a0, 1);
        chk("R1 data acks", {a1, a2}, 2'b11);
        chk("R2 divider", div_ratio, 15'h1234);
        chk("R9 one div strobe", n_div, 1);
        chk("R9 no ctl strobe", n_ctl, 0);
    endtask

    task automatic t_ctl();
        logic a;
        bus_start(); send_byte(AW, a); send_byte(8'hED, a); send_byte(8'hF5, a); bus_stop();
        chk("R3 control bits", ctl_bits, 6'h2D);
        chk("R3 band bits", band_sel, 4'h5);
        chk("R3 divider untouched", div_ratio, 15'h1234);
        chk("R9 one ctl strobe", n_ctl, 1);
    endtask

    task automatic t_four();
        logic a;
        bus_start(); send_byte(AW, a);
        send_byte(8'h93, a); send_byte(8'h0A, a); send_byte(8'h05, a); send_byte(8'h67, a);
        bus_stop();
        chk("R4 ctl-first ctl", ctl_bits, 6'h13);
        chk("R4 ctl-first band", band_sel, 4'hA);
        chk("R4 ctl-first div", div_ratio, 15'h0567);
        chk("R4 ctl-first strobes", {n_div[7:0], n_ctl[7:0]}, {8'd2, 8'd2});
        bus_start(); send_byte(AW, a);
        send_byte(8'h7F, a); send_byte(8'hFF, a); send_byte(8'hC0, a); send_byte(8'h03, a);
        bus_stop();
        chk("R4 div-first div", div_ratio, 15'h7FFF);
        chk("R4 div-first ctl", ctl_bits, 6'h00);
        chk("R4 div-first band", band_sel, 4'h3);
    endtask

    task automatic t_odd();
        logic a;
        bus_start(); send_byte(AW, a);
        send_byte(8'h01, a); send_byte(8'h02, a); send_byte(8'hBF, a);
        bus_stop();
        chk("R5 complete pair kept", div_ratio, 15'h0102);
        chk("R5 lone byte dropped", ctl_bits, 6'h00);
        chk("R5 strobe count", n_ctl, 3);
    endtask

    task automatic t_fifth();
        logic a;
        bus_start(); send_byte(AW, a);
        send_byte(8'h00, a); send_byte(8'h11, a); send_byte(8'h80, a); send_byte(8'h00, a);
        send_byte(8'h22, a);
        chk("R6 fifth byte not acked", a, 0);
        send_byte(8'h33, a);
        bus_stop();
        chk("R6 div from first pair", div_ratio, 15'h0011);
        chk("R6 band unaffected by extra bytes", band_sel, 4'h0);
    endtask

    task automatic t_read();
        logic a; logic [7:0] s;
        pll_locked = 1'b1; aux_status = 3'b101;
        bus_start(); send_byte(AR, a); read_byte(s); bus_stop();
        chk("R1 read address ack", a, 1);
        chk("R7 R8 first status", s, 8'hC5);
        pll_locked = 1'b0; aux_status = 3'b010;
        bus_start(); send_byte(AR, a); read_byte(s); bus_stop();
        chk("R8 POR cleared", s, 8'h02);
        bus_start(); send_byte(8'hC3, a); bus_stop();
        chk("R1 mismatched read not acked", a, 0);
    endtask

    task automatic t_restart();
        logic a;
        bus_start(); send_byte(AW, a); send_byte(8'h55, a);
        bus_start(); send_byte(AW, a);
        chk("R10 address acked after repeated start", a, 1);
        send_byte(8'h81, a); send_byte(8'h07, a); bus_stop();
        chk("R10 ctl after restart", ctl_bits, 6'h01);
        chk("R10 band after restart", band_sel, 4'h7);
        chk("R10 lone byte discarded", div_ratio, 15'h0011);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #3ns rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #5ns;
        t_reset();
        t_bad_addr();
        t_div();
        t_ctl();
        t_four();
        t_odd();
        t_fifth();
        t_read();
        t_restart();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule